// File: doc/BRIEF.md
# Parallel Odd-Syndrome Calculator for a Binary BCH Decoder

This block takes a received BCH codeword, message and parity together, as it arrives a fixed number of bits per clock. For a binary code with a correction strength of fifteen it keeps fifteen syndrome accumulators over GF(2^13), one for each odd power of alpha from alpha^1 to alpha^29. The even-indexed syndromes are squares of the odd ones, so the block does not compute them and leaves that to the stage that consumes its results.

Each accepted beat folds into every accumulator in a single step. The accumulator is multiplied by the power of alpha that shifts it past a whole beat, and the weighted contribution of the new bits is added in. One clock per beat is enough to keep up with the data stream.

A start strobe opens a codeword and a last flag closes it. One cycle after the closing beat a done strobe rises, and at the same time the syndrome bus and an error-present flag hold their final values. The locator solver and the Chien search further down the decoder are started only when that flag is set.

Top module: `syn_calc_top`

## Requirements
- R1: While rst_n is low at a clock edge, the next state is all syndromes zero and done_o low. As a result err_o is also low.
- R2: A cycle with start_i high and valid_i low clears every syndrome to zero at the next edge.
- R3: A cycle with valid_i high updates each syndrome S_j (j = 1, 3, …, 29) at the edge. The new value is S_j·alpha^(8j) XOR the sum over i of data_i[i]·alpha^(j·i). So data_i[7] is the earliest and highest-order bit of the beat, and the last bit of the codeword has weight alpha^0.
- R4: The field is GF(2^13) with primitive polynomial x^13 + x^4 + x^3 + x + 1, and alpha = x. S_(2k+1) appears on syn_o[13k+12:13k] for k = 0 to 14.
- R5: A cycle with start_i and valid_i both high treats the beat as the first beat of a new codeword. The old syndromes are discarded and each S_j becomes the contribution of that beat alone.
- R6: A cycle with neither start_i nor valid_i leaves every syndrome unchanged.
- R7: done_o is high for exactly the cycle after each cycle with valid_i and last_i both high, and is low otherwise.
- R8: err_o is high exactly when at least one syndrome bit is nonzero. An all-zero codeword therefore ends with err_o low, and any single-bit codeword ends with err_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a new codeword and clears the accumulators |
| valid_i | input | 1 | data_i carries a beat |
| data_i | input | 8 | Received bits; bit 7 is the earliest |
| last_i | input | 1 | Marks the final beat of the codeword; used with valid_i |
| syn_o | output | 195 | Fifteen 13-bit odd syndromes, S1 in the lowest slice |
| err_o | output | 1 | High when any syndrome is nonzero |
| done_o | output | 1 | One-cycle strobe after the final beat |

## Verification
The embedded properties check three things on every cycle. A lone start empties each accumulator, an idle cycle freezes it, and done appears exactly one cycle after a closing beat and at no other time. Whether the field arithmetic is right can only be shown by the bench's scenarios. These compare every syndrome on every clock with an independent bit-serial model, and they cover the bit order inside a beat, a start that coincides with data, gaps between beats, back-to-back codewords, and the zero and single-bit cases that set the error flag.

// File: rtl/bch_syn_pkg.sv
// Package: Galois-field helpers shared by the syndrome calculator.
// Assumes a binary extension field with alpha = x as primitive element.
package bch_syn_pkg;
    parameter int GF_M = 13;
    parameter int GF_ORDER = (1 << GF_M) - 1;
    // low-order terms of x^13 + x^4 + x^3 + x + 1
    parameter logic [GF_M-1:0] GF_POLY = 13'h001B;

    typedef logic [GF_M-1:0] gf_t;

    // multiply an element by alpha
    function automatic gf_t gf_xtime(input gf_t a);
        gf_t r;
        r = {a[GF_M-2:0], 1'b0};
        if (a[GF_M-1]) r = r ^ GF_POLY;
        return r;
    endfunction

    // general field product, shift-and-add from the top bit of b
    function automatic gf_t gf_mul(input gf_t a, input gf_t b);
        gf_t p;
        p = '0;
        for (int i = GF_M - 1; i >= 0; i--) begin
            p = gf_xtime(p);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    // alpha raised to e, by square-and-multiply
    function automatic gf_t gf_pow(input int unsigned e);
        gf_t r;
        gf_t b;
        int unsigned k;
        r = gf_t'(1);
        b = gf_t'(2);
        k = e % GF_ORDER;
        for (int i = 0; i < 32; i++) begin
            if (k[i]) r = gf_mul(r, b);
            b = gf_mul(b, b);
        end
        return r;
    endfunction
endpackage

// File: rtl/syn_lane.sv
// Module: one syndrome accumulator, evaluating the received polynomial at
// alpha^J for a beat of W bits per clock (Horner form over whole beats).
// Assumes data[W-1] is the earliest bit of the beat.
module syn_lane
    import bch_syn_pkg::*;
#(
    parameter int J = 1,
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         load,
    input  logic [W-1:0] data,
    output gf_t          syn
);
    // weights alpha^(J*i) of bit i inside one beat
    function automatic logic [W*GF_M-1:0] build_cols();
        logic [W*GF_M-1:0] c;
        c = '0;
        for (int i = 0; i < W; i++) c[i*GF_M +: GF_M] = gf_pow(J * i);
        return c;
    endfunction

    localparam gf_t STEP = gf_pow(J * W);
    localparam logic [W*GF_M-1:0] COLS = build_cols();

    gf_t contrib;
    gf_t base;

    // sum of weighted bits of the current beat
    always_comb begin
        contrib = '0;
        for (int i = 0; i < W; i++) begin
            if (data[i]) contrib = contrib ^ COLS[i*GF_M +: GF_M];
        end
    end

    // previous value shifted by one beat, or zero when a codeword opens
    always_comb begin
        base = clear ? '0 : gf_mul(syn, STEP);
    end

    // accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n)     syn <= '0;
        else if (load)  syn <= base ^ contrib;
        else if (clear) syn <= '0;
    end

    AST_LANE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear && !load |=> syn == '0); // R2
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clear && !load |=> $stable(syn)); // R6
endmodule

// File: rtl/syn_ctrl.sv
// Module: completion strobe, raised the cycle after a closing beat.
// Assumes last is meaningful only with valid.
module syn_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic last,
    output logic done
);
    // register the closing-beat condition
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= valid & last;
    end

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        valid && last |=> done); // R7
    AST_DONE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(valid && last)); // R7
endmodule

// File: rtl/syn_any.sv
// Module: nonzero detector over N syndromes of GF_M bits each.
// Assumes the syndromes are packed lowest index first.
module syn_any
    import bch_syn_pkg::*;
#(
    parameter int N = 15
) (
    input  logic [N*GF_M-1:0] vec,
    output logic              any
);
    logic [N-1:0] nz;

    for (genvar k = 0; k < N; k++) begin : g_nz
        // per-syndrome nonzero bit
        assign nz[k] = |vec[k*GF_M +: GF_M];
    end

    // combine all syndromes
    assign any = |nz;
endmodule

// File: rtl/syn_calc_top.sv
// Module: parallel odd-syndrome calculator for a binary BCH code over
// GF(2^13). One lane per odd syndrome, an error-present flag and a done strobe.
// Assumes a codeword is always opened with start_i.
module syn_calc_top
    import bch_syn_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int NUM_SYN = 15,
    localparam int SYN_W = NUM_SYN * GF_M
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              valid_i,
    input  logic [BEAT_W-1:0] data_i,
    input  logic              last_i,
    output logic [SYN_W-1:0]  syn_o,
    output logic              err_o,
    output logic              done_o
);
    for (genvar k = 0; k < NUM_SYN; k++) begin : g_lane
        gf_t s;
        syn_lane #(.J(2 * k + 1), .W(BEAT_W)) u_lane (
            .clk  (clk),
            .rst_n(rst_n),
            .clear(start_i),
            .load (valid_i),
            .data (data_i),
            .syn  (s)
        );
        // place S(2k+1) in slice k
        assign syn_o[k*GF_M +: GF_M] = s;
    end

    syn_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .valid(valid_i),
        .last (last_i),
        .done (done_o)
    );

    syn_any #(.N(NUM_SYN)) u_any (
        .vec(syn_o),
        .any(err_o)
    );
endmodule

// File: tb/syn_calc_top_test.sv
// Bench: a bit-serial behavioural model, compared with the outputs on every clock.
module syn_calc_top_test;
    localparam int W = 8;
    localparam int NS = 15;
    localparam int M = 13;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          valid_i = 1'b0;
    logic [W-1:0]  data_i = '0;
    logic          last_i = 1'b0;
    logic [NS*M-1:0] syn_o;
    logic          err_o;
    logic          done_o;

    syn_calc_top uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
        .data_i(data_i), .last_i(last_i), .syn_o(syn_o), .err_o(err_o),
        .done_o(done_o)
    );

    int nchk = 0;
    int nerr = 0;
    int msyn[NS];
    bit exp_done = 1'b0;

    function automatic int xt(input int s);
        int r;
        r = s << 1;
        if ((r & 32'h2000) != 0) r = r ^ 32'h201B;
        return r;
    endfunction

    // serial Horner step for one received bit
    task automatic push_bit(input bit b);
        for (int k = 0; k < NS; k++) begin
            int s;
            s = msyn[k];
            for (int t = 0; t < 2 * k + 1; t++) s = xt(s);
            msyn[k] = s ^ int'(b);
        end
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [NS*M-1:0] act, input logic [NS*M-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cycle(input bit st, input bit v, input bit l,
                         input logic [W-1:0] d, input string req);
        logic [NS*M-1:0] e;
        bit ee;
        @(negedge clk);
        start_i = st; valid_i = v; last_i = l; data_i = d;
        @(posedge clk);
        if (!rst_n) begin
            foreach (msyn[k]) msyn[k] = 0;
            exp_done = 1'b0;
        end else begin
            if (st) foreach (msyn[k]) msyn[k] = 0;
            if (v) for (int i = W - 1; i >= 0; i--) push_bit(d[i]);
            exp_done = v && l;
        end
        #1;
        e = '0;
        ee = 1'b0;
        for (int k = 0; k < NS; k++) begin
            e[k*M +: M] = M'(msyn[k]);
            if (msyn[k] != 0) ee = 1'b1;
        end
        check(syn_o === e, req, "syndromes", syn_o, e);
        check(done_o === exp_done, "R7", "done", {194'd0, done_o}, {194'd0, exp_done});
        check(err_o === ee, "R8", "err", {194'd0, err_o}, {194'd0, ee});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        foreach (msyn[k]) msyn[k] = 0;
        // R1 reset state
        rst_n = 1'b0;
        repeat (3) cycle(1'b0, 1'b1, 1'b1, 8'hA5, "R1");
        rst_n = 1'b1;
        // R8 all-zero codeword gives no error
        cycle(1'b1, 1'b1, 1'b0, 8'h00, "R5");
        repeat (6) cycle(1'b0, 1'b1, 1'b0, 8'h00, "R3");
        cycle(1'b0, 1'b1, 1'b1, 8'h00, "R8");
        // R4 single bit of weight alpha^0 on the last bit
        cycle(1'b1, 1'b0, 1'b0, 8'h00, "R2");
        cycle(1'b0, 1'b1, 1'b1, 8'h01, "R4");
        // R3 single earliest bit of a beat
        cycle(1'b1, 1'b1, 1'b0, 8'h80, "R5");
        cycle(1'b0, 1'b1, 1'b1, 8'h00, "R3");
        // R3 random codeword with gaps (R6)
        cycle(1'b1, 1'b0, 1'b0, 8'hFF, "R2");
        for (int n = 0; n < 40; n++) begin
            cycle(1'b0, 1'b1, 1'b0, 8'($urandom), "R3");
            if ((n % 7) == 3) cycle(1'b0, 1'b0, 1'b1, 8'($urandom), "R6");
        end
        cycle(1'b0, 1'b1, 1'b1, 8'($urandom), "R3");
        repeat (3) cycle(1'b0, 1'b0, 1'b0, 8'h5A, "R6");
        // R5 back-to-back codewords, start with data right after last
        for (int c = 0; c < 4; c++) begin
            cycle(1'b1, 1'b1, 1'b0, 8'($urandom), "R5");
            for (int n = 0; n < 10; n++) cycle(1'b0, 1'b1, 1'b0, 8'($urandom), "R3");
            cycle(1'b0, 1'b1, 1'b1, 8'($urandom), "R7");
        end
        // R2 lone start after a finished codeword
        cycle(1'b1, 1'b0, 1'b0, 8'hC3, "R2");
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R6");
        // R1 reset in the middle of a codeword
        cycle(1'b1, 1'b1, 1'b0, 8'h3C, "R5");
        rst_n = 1'b0;
        cycle(1'b0, 1'b1, 1'b1, 8'h11, "R1");
        rst_n = 1'b1;
        cycle(1'b0, 1'b0, 1'b0, 8'h00, "R1");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule